// File: doc/BRIEF.md
# Done-Flag Join with Cross-Domain Completion and Clear

This block gathers a vector of per-task completion flags in a source clock domain. Each flag is set by a one-cycle strobe and stays set. The AND of all flags is captured in a source register. Only that registered bit crosses into an unrelated destination clock domain. No combinational wide AND ever feeds the crossing.

In the destination domain a small state machine watches the synchronized all-done bit. It must see the bit high on a programmable number of consecutive edges before it accepts it. It then emits a single completion pulse and raises a clear request. The request travels back to the source domain through a synchronizer and an edge detector. That path produces exactly one source cycle of clear, which drops every flag at once.

The destination states are IDLE, QUAL, FIRE and HOLD:
- IDLE goes to QUAL on the first high sample.
- QUAL returns to IDLE on any low sample. It goes to FIRE once the required run of high samples is complete.
- FIRE always moves to HOLD after one cycle.
- HOLD returns to IDLE only once the synchronized all-done is seen low again.

Top module: `flagjoin_cdc`

## Requirements
- R1: A high bit i of `set_stb` at a source clock edge sets flag i at that edge. A set flag stays 1 at every later edge until a clear is applied. Flag i appears on bit i of `flags`.
- R2: No completion pulse occurs while any flag is 0.
- R3: Once all NFLAG flags are 1, exactly one completion pulse follows, one destination cycle wide. After it, all flags return to 0 with a clear lasting exactly one source cycle.
- R4: When a set strobe and the clear fall in the same source cycle, the clear wins and the flag is left at 0.
- R5: Each round gives one pulse only. A new pulse needs the all-done indication to have fallen and all flags to be set again.
- R6: After reset, `flags` is all zeros and `done_pulse` is 0.
- R7: The pulse is issued only after the synchronized all-done has been high on QUAL_CNT consecutive destination edges (QUAL_CNT is 2 or 3, default 3). The pulse therefore comes at least QUAL_CNT+2 destination cycles after the flags become all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| set_stb | input | NFLAG | Per-flag set strobes, source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| done_pulse | output | 1 | One-cycle completion pulse, destination domain |
| flags | output | NFLAG | Current flag vector, source domain |

## Verification
Assertions check four things on every cycle:
- Flags are sticky between clears.
- A clear leaves the vector at zero.
- The registered all-done never reads 1 with a flag low.
- The clear and the completion pulse are each one cycle wide, and the pulse follows a run of at least QUAL_CNT high samples.

Only the bench scenarios can show the cross-domain behaviour:
- A full round yields exactly one pulse, and the flags come back cleared.
- A strobe that lands on the clear cycle is dropped.
- The machine does not re-arm until a fresh round completes.

// File: rtl/flagjoin_pkg.sv
package flagjoin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_QUAL,
        ST_FIRE,
        ST_HOLD
    } dst_state_e;
endpackage

// File: rtl/fj_sync2.sv
module fj_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;
    logic out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            out_q  <= 1'b0;
        end else begin
            meta_q <= d;
            out_q  <= meta_q;
        end
    end

    assign q = out_q;
endmodule

// File: rtl/fj_flag_bank.sv
module fj_flag_bank #(
    parameter int NFLAG = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_stb,
    input  logic             clr,
    output logic [NFLAG-1:0] flags,
    output logic             all_done
);
    logic [NFLAG-1:0] flags_q;
    logic             all_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            all_q   <= 1'b0;
        end else if (clr) begin
            flags_q <= '0;
            all_q   <= 1'b0;
        end else begin
            flags_q <= flags_q | set_stb;
            all_q   <= &flags_q;
        end
    end

    assign flags    = flags_q;
    assign all_done = all_q;

    // R1
    sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    // R4
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags_q == '0));
    // R2
    all_implies_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_q |-> (&flags_q));
endmodule

// File: rtl/fj_clr_return.sv
module fj_clr_return (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic clr_pulse
);
    logic req_s;
    logic prev_q;
    logic pulse_q;

    fj_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_async),
        .q     (req_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= req_s;
            pulse_q <= req_s & ~prev_q;
        end
    end

    assign clr_pulse = pulse_q;

    // R3
    single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
endmodule

// File: rtl/fj_dst_ctrl.sv
module fj_dst_ctrl
    import flagjoin_pkg::*;
#(
    parameter int QUAL_CNT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic all_s,
    output logic done_pulse,
    output logic clr_req
);
    localparam int CW = $clog2(QUAL_CNT + 1);

    dst_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (all_s) begin
                    state_d = ST_QUAL;
                    cnt_d   = CW'(1);
                end
            end
            ST_QUAL: begin
                if (!all_s) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CW'(QUAL_CNT - 1)) begin
                    state_d = ST_FIRE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_FIRE: state_d = ST_HOLD;
            ST_HOLD: begin
                if (!all_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        done_pulse = (state_q == ST_FIRE);
        clr_req    = (state_q == ST_FIRE) || (state_q == ST_HOLD);
    end

    logic [2:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            run_q <= '0;
        else if (!all_s)       run_q <= '0;
        else if (run_q != 3'h7) run_q <= run_q + 3'h1;
    end

    // R7
    qual_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (run_q >= 3'(QUAL_CNT)));
    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    // R5
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && all_s) |=> clr_req);
endmodule

// File: rtl/flagjoin_cdc.sv
module flagjoin_cdc #(
    parameter int NFLAG    = 24,
    parameter int QUAL_CNT = 3
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic [NFLAG-1:0] set_stb,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic             done_pulse,
    output logic [NFLAG-1:0] flags
);
    logic all_src;
    logic all_dst;
    logic clr_req;
    logic clr_src;

    fj_flag_bank #(.NFLAG(NFLAG)) u_bank (
        .clk      (src_clk),
        .rst_n    (src_rst_n),
        .set_stb  (set_stb),
        .clr      (clr_src),
        .flags    (flags),
        .all_done (all_src)
    );

    fj_sync2 u_all_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (all_src),
        .q     (all_dst)
    );

    fj_dst_ctrl #(.QUAL_CNT(QUAL_CNT)) u_ctrl (
        .clk        (dst_clk),
        .rst_n      (dst_rst_n),
        .all_s      (all_dst),
        .done_pulse (done_pulse),
        .clr_req    (clr_req)
    );

    fj_clr_return u_ret (
        .clk       (src_clk),
        .rst_n     (src_rst_n),
        .req_async (clr_req),
        .clr_pulse (clr_src)
    );
endmodule

// File: tb/sim_flagjoin_cdc.sv
module sim_flagjoin_cdc;
    localparam int N = 24;
    localparam int Q = 3;

    logic src_clk = 1'b0;
    logic dst_clk = 1'b0;
    logic src_rst_n = 1'b0;
    logic dst_rst_n = 1'b0;
    logic [N-1:0] set_stb = '0;
    logic done_pulse;
    logic [N-1:0] flags;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int dst_cyc = 0;
    int pulse_cyc = 0;
    int full_cyc = 0;
    bit finished = 0;

    always #10 src_clk = ~src_clk;
    initial begin
        #3;
        forever #4 dst_clk = ~dst_clk;
    end

    flagjoin_cdc #(.NFLAG(N), .QUAL_CNT(Q)) u0 (
        .src_clk    (src_clk),
        .src_rst_n  (src_rst_n),
        .set_stb    (set_stb),
        .dst_clk    (dst_clk),
        .dst_rst_n  (dst_rst_n),
        .done_pulse (done_pulse),
        .flags      (flags)
    );

    always @(negedge dst_clk) begin
        dst_cyc <= dst_cyc + 1;
        if (dst_rst_n && done_pulse) begin
            pulses    <= pulses + 1;
            pulse_cyc <= dst_cyc;
        end
    end

    // strobe mask, expected flags afterwards
    localparam logic [47:0] STEPS [5] = '{
        {24'h000001, 24'h000001},
        {24'h800000, 24'h800001},
        {24'h00FF00, 24'h80FF01},
        {24'h000001, 24'h80FF01},
        {24'h7F00FE, 24'hFFFFFF}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [N-1:0] m);
        @(negedge src_clk);
        set_stb = m;
        @(negedge src_clk);
        set_stb = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge src_clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge src_clk);
        // R6
        chk(flags == '0, "R6 flags", int'(flags), 0);
        chk(done_pulse == 1'b0, "R6 pulse", int'(done_pulse), 0);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        repeat (2) @(negedge src_clk);

        for (int i = 0; i < 5; i++) begin
            strobe(STEPS[i][47:24]);
            if (i == 4) full_cyc = dst_cyc;
            // R1
            chk(flags == STEPS[i][23:0], "R1 accumulate", int'(flags), int'(STEPS[i][23:0]));
            if (i < 4) begin
                repeat (6) @(negedge src_clk);
                // R2
                chk(pulses == 0, "R2 no early pulse", pulses, 0);
            end
        end

        repeat (25) @(negedge src_clk);
        // R3
        chk(pulses == 1, "R3 one pulse", pulses, 1);
        chk(flags == '0, "R3 flags cleared", int'(flags), 0);
        // R7
        chk(pulse_cyc - full_cyc >= Q + 2, "R7 qualification latency", pulse_cyc - full_cyc, Q + 2);
        repeat (30) @(negedge src_clk);
        // R5
        chk(pulses == 1, "R5 no re-arm", pulses, 1);

        // R4: hold bit 5 strobe through the clear
        @(negedge src_clk);
        set_stb = '1;
        @(negedge src_clk);
        set_stb = 24'h000020;
        for (int k = 0; k < 100; k++) begin
            @(negedge src_clk);
            if (flags != '1) break;
        end
        chk(flags == '0, "R4 clear beats set", int'(flags), 0);
        @(negedge src_clk);
        chk(flags == 24'h000020, "R4 set after clear", int'(flags), 'h20);
        set_stb = '0;
        repeat (30) @(negedge src_clk);
        chk(pulses == 2, "R5 partial round no pulse", pulses, 2);
        chk(flags == 24'h000020, "R1 sticky partial", int'(flags), 'h20);

        strobe(24'hFFFFDF);
        repeat (30) @(negedge src_clk);
        chk(pulses == 3, "R5 re-arm after fresh round", pulses, 3);
        chk(flags == '0, "R3 flags cleared again", int'(flags), 0);

        finish_run();
    end
endmodule